// File: doc/BRIEF.md
# Serial Flash Status-Register and Write-Protect Controller

This block holds the two status bytes of a small serial NOR flash and decides, for every decoded instruction, whether it is carried out or refused. Instructions arrive one per cycle as an opcode with a target address and a data word. Within one decision path the block applies four checks: an operation still running, the write-enable latch, the protect-lock bits together with the write-protect pin, and a programmable protected address range. Each instruction gets exactly one answer: a one-cycle grant pulse or a one-cycle reject pulse.

A granted program, erase, security-area write or status write raises the busy flag. A cycle counter then stands in for the real operation time. A running program or erase can be paused with the suspend opcode and later continued with the same opcode. The serial shift logic, the array itself and the analog timing are outside the block.

Top module: `flash_status_ctrl`

## Requirements
- R1: After reset, status1 and status2 read 0x00, busy is 0, and neither cmd_grant nor cmd_reject is high.
- R2: Each cycle with cmd_valid high is answered in the next cycle by exactly one of cmd_grant and cmd_reject. The opcodes are 0 write-enable, 1 write-disable, 2 status write, 3 page program, 4 sector erase (4 KB), 5 block erase (64 KB), 6 chip erase, 7 suspend/resume and 8 security-area write. Codes 9 to 15 are rejected.
- R3: A granted write-enable sets the latch in status1 bit 1, and a granted write-disable clears it.
- R4: A granted program, security-area write, erase or status write holds busy, mirrored in status1 bit 0, high for exactly the configured cycle count of that operation. Busy is counted from the cycle after the grant.
- R5: While busy is 1, every opcode other than suspend is rejected and changes no state.
- R6: Program, erase and security-area write are rejected while the latch is 0. A rejected command leaves the latch unchanged. Starting any timed operation clears the latch. The security-area write has no address-range check.
- R7: The protected size comes from status1 bits 4:2 (level), bit 5 (bottom select) and bit 6 (sector granularity). Level 0 protects nothing. With granularity 0, levels 1 to 4 protect 64, 128, 256 and 512 KB, and levels 5 to 7 protect the whole 1 MB. With granularity 1, levels 1, 2, 3 and 4 to 7 protect 4, 8, 16 and 32 KB.
- R8: With bottom select 0 the range ends at the top address; with 1 it starts at address 0. A program or erase is rejected if any byte of its page, sector, block or the whole chip falls in the range. A chip erase is therefore rejected whenever the level is nonzero.
- R9: A status write needs the latch set, needs status2 bit 0 clear, and with status1 bit 7 set also needs wp_n high. When granted, data bits 7:2 load status1 bits 7:2 and data bit 8 loads status2 bit 0.
- R10: Once status2 bit 0 is 1, every status write is rejected until reset.
- R11: A suspend issued while a program, erase or security-area write runs is granted, drops busy, sets status2 bit 7 and freezes the remaining count. A suspend issued in the final busy cycle or during a status write is rejected. While suspended, a second suspend resumes the operation for the cycles that remain. Status write, program, erase and security-area write are rejected during suspension. A suspend issued while idle is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| cmd_valid | input | 1 | An instruction is presented this cycle |
| cmd_op | input | 4 | Instruction opcode |
| cmd_addr | input | ADDR_W (20) | Target byte address for program and erase |
| cmd_data | input | 16 | Status-write data word |
| wp_n | input | 1 | Write-protect pin, active low |
| status1 | output | 8 | Status byte 1 |
| status2 | output | 8 | Status byte 2 |
| busy | output | 1 | An operation is running |
| cmd_grant | output | 1 | The previous cycle's instruction was carried out |
| cmd_reject | output | 1 | The previous cycle's instruction was refused |

## Verification
Every piece of internal state reaches the ports within one cycle. A wrong latch, protection field or lock bit shows in status1 or status2 right after the granting edge, and it also flips the grant/reject answer of the next instruction that depends on it. A counter fault shows as a busy window that is longer or shorter than the configured count, and it is found when busy falls. A suspend that freezes the count wrongly shows only after resume, as a wrong number of remaining busy cycles.

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl #(
  parameter int ADDR_W   = 20,
  parameter int SECT_W   = 12,
  parameter int BLK_W    = 16,
  parameter int PROG_CYC = 4,
  parameter int SECT_CYC = 6,
  parameter int BLK_CYC  = 8,
  parameter int CHIP_CYC = 12,
  parameter int WRSR_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [15:0]       cmd_data,
  input  logic              wp_n,
  output logic [7:0]        status1,
  output logic [7:0]        status2,
  output logic              busy,
  output logic              cmd_grant,
  output logic              cmd_reject
);

  localparam logic [3:0] OP_WREN = 4'd0, OP_WRDI = 4'd1, OP_WRSR = 4'd2,
                         OP_PROG = 4'd3, OP_SERASE = 4'd4, OP_BERASE = 4'd5,
                         OP_CERASE = 4'd6, OP_SUSP = 4'd7, OP_SECW = 4'd8;
  localparam int MAX_A   = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int MAX_B   = (BLK_CYC > CHIP_CYC) ? BLK_CYC : CHIP_CYC;
  localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_CYC = (MAX_C > WRSR_CYC) ? MAX_C : WRSR_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic              wel, tb, sec, srp0, srp1, busy_q, susp, wrsr_run;
  logic [2:0]        lvl;
  logic [CNT_W-1:0]  cnt, dur;
  logic              ok, hit, wrsr_ok, idle_free;
  logic [ADDR_W:0]   prot_size, top_start;
  logic [ADDR_W-1:0] unit_mask, lo, hi;
  int                shamt;
  logic              unused_data;

  assign unused_data = ^{cmd_data[15:9], cmd_data[1:0]};

  always_comb begin
    shamt     = 0;
    prot_size = '0;
    if (lvl != 3'd0) begin
      if (sec)               shamt = SECT_W - 1 + ((lvl > 3'd4) ? 4 : int'(lvl));
      else if (lvl >= 3'd5)  shamt = ADDR_W;
      else                   shamt = ADDR_W - 5 + int'(lvl);
      prot_size = (ADDR_W+1)'(1) << shamt;
    end
  end

  always_comb begin
    case (cmd_op)
      OP_SERASE: unit_mask = ADDR_W'((1 << SECT_W) - 1);
      OP_BERASE: unit_mask = ADDR_W'((1 << BLK_W) - 1);
      OP_CERASE: unit_mask = {ADDR_W{1'b1}};
      default:   unit_mask = '0;
    endcase
  end

  assign lo        = cmd_addr & ~unit_mask;
  assign hi        = cmd_addr | unit_mask;
  assign top_start = {1'b1, {ADDR_W{1'b0}}} - prot_size;
  assign hit       = (prot_size != '0) &&
                     (tb ? ({1'b0, lo} < prot_size) : ({1'b0, hi} >= top_start));
  assign wrsr_ok   = wel && !srp1 && !(srp0 && !wp_n);
  assign idle_free = !busy_q && !susp;

  always_comb begin
    ok  = 1'b0;
    dur = '0;
    case (cmd_op)
      OP_WREN, OP_WRDI: ok = !busy_q;
      OP_WRSR: begin ok = idle_free && wrsr_ok; dur = CNT_W'(WRSR_CYC); end
      OP_PROG: begin ok = idle_free && wel && !hit; dur = CNT_W'(PROG_CYC); end
      OP_SERASE: begin ok = idle_free && wel && !hit; dur = CNT_W'(SECT_CYC); end
      OP_BERASE: begin ok = idle_free && wel && !hit; dur = CNT_W'(BLK_CYC); end
      OP_CERASE: begin ok = idle_free && wel && !hit; dur = CNT_W'(CHIP_CYC); end
      OP_SECW: begin ok = idle_free && wel; dur = CNT_W'(PROG_CYC); end
      OP_SUSP: ok = susp || (busy_q && !wrsr_run && cnt != CNT_W'(1));
      default: ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel <= 1'b0; lvl <= '0; tb <= 1'b0; sec <= 1'b0; srp0 <= 1'b0; srp1 <= 1'b0;
      busy_q <= 1'b0; susp <= 1'b0; wrsr_run <= 1'b0; cnt <= '0;
      cmd_grant <= 1'b0; cmd_reject <= 1'b0;
    end else begin
      cmd_grant  <= cmd_valid && ok;
      cmd_reject <= cmd_valid && !ok;
      if (busy_q) begin
        if (cnt == CNT_W'(1)) busy_q <= 1'b0;
        else                  cnt <= cnt - CNT_W'(1);
      end
      if (cmd_valid && ok) begin
        case (cmd_op)
          OP_WREN: wel <= 1'b1;
          OP_WRDI: wel <= 1'b0;
          OP_SUSP: begin
            busy_q <= susp;
            susp   <= !susp;
          end
          default: begin
            busy_q   <= 1'b1;
            cnt      <= dur;
            wel      <= 1'b0;
            wrsr_run <= (cmd_op == OP_WRSR);
            if (cmd_op == OP_WRSR) begin
              {srp0, sec, tb, lvl} <= cmd_data[7:2];
              srp1 <= cmd_data[8];
            end
          end
        endcase
      end
    end
  end

  assign busy    = busy_q;
  assign status1 = {srp0, sec, tb, lvl, wel, busy_q};
  assign status2 = {susp, 6'b0, srp1};

endmodule

// File: rtl/flash_status_ctrl_chk.sv
module flash_status_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [3:0] cmd_op,
  input logic [7:0] status1,
  input logic [7:0] status2,
  input logic       busy,
  input logic       cmd_grant,
  input logic       cmd_reject
);

  assert_one_answer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> (cmd_grant ^ cmd_reject));

  assert_silent_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> (!cmd_grant && !cmd_reject));

  assert_busy_rise_granted_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> cmd_grant);

  assert_busy_filter_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid && cmd_op != 4'd7) |=> cmd_reject);

  assert_reject_keeps_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject |-> (status1[1] == $past(status1[1])));

  assert_start_clears_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !$past(status2[7])) |-> !status1[1]);

  assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    status2[0] |=> status2[0]);

  assert_busy_susp_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && status2[7]));

endmodule

bind flash_status_ctrl flash_status_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .status1(status1), .status2(status2), .busy(busy),
  .cmd_grant(cmd_grant), .cmd_reject(cmd_reject)
);

// File: tb/flash_status_ctrl_tb.sv
module flash_status_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PROG_C = 4, SECT_C = 6, BLK_C = 8, CHIP_C = 12, WRSR_C = 3;

  logic        clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0, wp_n = 1'b1;
  logic [3:0]  cmd_op = '0;
  logic [19:0] cmd_addr = '0;
  logic [15:0] cmd_data = '0;
  logic [7:0]  status1, status2;
  logic        busy, cmd_grant, cmd_reject;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_ctrl #(.ADDR_W(20), .SECT_W(12), .BLK_W(16), .PROG_CYC(PROG_C),
    .SECT_CYC(SECT_C), .BLK_CYC(BLK_C), .CHIP_CYC(CHIP_C), .WRSR_CYC(WRSR_C)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .wp_n(wp_n), .status1(status1),
    .status2(status2), .busy(busy), .cmd_grant(cmd_grant), .cmd_reject(cmd_reject));

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] op, input logic [19:0] a, input logic [15:0] d,
                      output logic g);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    g = cmd_grant;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic set_sr(input logic [7:0] v, input logic lock);
    logic g; int n;
    send(4'd0, '0, '0, g);
    send(4'd2, '0, {7'b0, lock, v}, g);
    check("R9", "status write grant", int'(g), 1);
    wait_idle(n);
  endtask

  task automatic t_reset;
    check("R1", "status1", int'(status1), 0);
    check("R1", "status2", int'(status2), 0);
    check("R1", "busy", int'(busy), 0);
    check("R1", "grant/reject", int'({cmd_grant, cmd_reject}), 0);
  endtask

  task automatic t_latch;
    logic g;
    send(4'd0, '0, '0, g);
    check("R3", "wren grant", int'(g), 1);
    check("R3", "latch set", int'(status1[1]), 1);
    send(4'd1, '0, '0, g);
    check("R3", "latch cleared", int'(status1[1]), 0);
    send(4'd9, '0, '0, g);
    check("R2", "undefined opcode reject", int'(cmd_reject), 1);
  endtask

  task automatic t_timing;
    logic g; int n;
    send(4'd3, '0, '0, g);
    check("R6", "program without latch", int'(cmd_reject), 1);
    check("R6", "no busy on reject", int'(busy), 0);
    send(4'd0, '0, '0, g);
    send(4'd3, 20'h00100, '0, g);
    check("R6", "program grant", int'(g), 1);
    check("R6", "latch cleared on start", int'(status1[1]), 0);
    check("R4", "busy bit", int'(status1[0]), 1);
    wait_idle(n);
    check("R4", "program cycles", n, PROG_C);
    send(4'd0, '0, '0, g);
    send(4'd4, 20'h12345, '0, g);
    wait_idle(n);
    check("R4", "sector erase cycles", n, SECT_C);
  endtask

  task automatic t_busy_filter;
    logic g; int n;
    send(4'd0, '0, '0, g);
    send(4'd5, '0, '0, g);
    send(4'd0, '0, '0, g);
    check("R5", "wren while busy", int'(cmd_reject), 1);
    check("R5", "latch untouched", int'(status1[1]), 0);
    send(4'd1, '0, '0, g);
    check("R5", "wrdi while busy", int'(cmd_reject), 1);
    wait_idle(n);
  endtask

  task automatic try_mod(input string req, input logic [3:0] op, input logic [19:0] a,
                         input logic exp);
    logic g; int n;
    send(4'd0, '0, '0, g);
    send(op, a, '0, g);
    check(req, $sformatf("op %0d addr %05h", op, a), int'(g), int'(exp));
    if (g) wait_idle(n);
    else begin
      check("R6", "latch kept after reject", int'(status1[1]), 1);
      send(4'd1, '0, '0, g);
    end
  endtask

  task automatic t_protect;
    int n; logic g;
    set_sr(8'h04, 1'b0);
    check("R7", "fields loaded", int'(status1), 8'h04);
    try_mod("R7", 4'd3, 20'hF0000, 1'b0);
    try_mod("R7", 4'd3, 20'hEFFFF, 1'b1);
    try_mod("R8", 4'd5, 20'hE0000, 1'b1);
    try_mod("R8", 4'd5, 20'hF1234, 1'b0);
    set_sr(8'h10, 1'b0);
    try_mod("R7", 4'd3, 20'h80000, 1'b0);
    try_mod("R7", 4'd3, 20'h7FFFF, 1'b1);
    set_sr(8'h14, 1'b0);
    try_mod("R7", 4'd3, 20'h00000, 1'b0);
    set_sr(8'h24, 1'b0);
    try_mod("R8", 4'd3, 20'h0FFFF, 1'b0);
    try_mod("R8", 4'd3, 20'h10000, 1'b1);
    try_mod("R8", 4'd6, 20'h00000, 1'b0);
    set_sr(8'h44, 1'b0);
    try_mod("R7", 4'd3, 20'hFF000, 1'b0);
    try_mod("R7", 4'd3, 20'hFEFFF, 1'b1);
    try_mod("R8", 4'd4, 20'hFE800, 1'b1);
    try_mod("R8", 4'd5, 20'hF0000, 1'b0);
    set_sr(8'h78, 1'b0);
    try_mod("R7", 4'd3, 20'h07FFF, 1'b0);
    try_mod("R7", 4'd3, 20'h08000, 1'b1);
    set_sr(8'h4C, 1'b0);
    try_mod("R8", 4'd4, 20'hFC000, 1'b0);
    try_mod("R8", 4'd4, 20'hFB000, 1'b1);
    set_sr(8'h1C, 1'b0);
    try_mod("R6", 4'd8, 20'h00000, 1'b1);
    set_sr(8'h00, 1'b0);
    send(4'd0, '0, '0, g);
    send(4'd6, 20'h00000, '0, g);
    check("R8", "chip erase unprotected", int'(g), 1);
    wait_idle(n);
    check("R4", "chip erase cycles", n, CHIP_C);
  endtask

  task automatic t_wp_pin;
    logic g; int n;
    send(4'd2, '0, '0, g);
    check("R9", "status write without latch", int'(g), 0);
    set_sr(8'h80, 1'b0);
    wp_n = 1'b0;
    send(4'd0, '0, '0, g);
    send(4'd2, '0, '0, g);
    check("R9", "pin blocks write", int'(g), 0);
    check("R9", "status1 kept", int'(status1), 8'h82);
    wp_n = 1'b1;
    send(4'd2, '0, '0, g);
    check("R9", "pin high allows write", int'(g), 1);
    wait_idle(n);
    check("R9", "status1 after write", int'(status1), 0);
  endtask

  task automatic t_suspend;
    logic g; int n;
    send(4'd7, '0, '0, g);
    check("R11", "suspend while idle", int'(g), 0);
    send(4'd0, '0, '0, g);
    send(4'd5, 20'h30000, '0, g);
    @(negedge clk);
    send(4'd7, '0, '0, g);
    check("R11", "suspend grant", int'(g), 1);
    check("R11", "busy dropped", int'(busy), 0);
    check("R11", "suspend flag", int'(status2[7]), 1);
    repeat (3) @(negedge clk);
    check("R11", "stays paused", int'(busy), 0);
    send(4'd0, '0, '0, g);
    check("R11", "wren while paused", int'(g), 1);
    send(4'd3, '0, '0, g);
    check("R11", "program while paused", int'(g), 0);
    send(4'd7, '0, '0, g);
    check("R11", "resume grant", int'(g), 1);
    check("R11", "flag cleared", int'(status2[7]), 0);
    wait_idle(n);
    check("R11", "remaining cycles", n, BLK_C - 2);
    send(4'd2, '0, '0, g);
    send(4'd7, '0, '0, g);
    check("R11", "suspend during status write", int'(g), 0);
    wait_idle(n);
  endtask

  task automatic t_lock;
    logic g;
    set_sr(8'h00, 1'b1);
    check("R10", "lock bit", int'(status2[0]), 1);
    send(4'd0, '0, '0, g);
    send(4'd2, '0, 16'h0004, g);
    check("R10", "write locked", int'(g), 0);
    check("R10", "status1 unchanged", int'(status1), 8'h02);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "status2 after reset", int'(status2), 0);
    check("R1", "status1 after reset", int'(status1), 0);
    set_sr(8'h04, 1'b0);
    check("R10", "write after reset", int'(status1), 8'h04);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_latch;
    t_timing;
    t_busy_filter;
    t_protect;
    t_wp_pin;
    t_suspend;
    t_lock;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule